// File: doc/BRIEF.md
# DRAM Bank Address and Access Decoder

This block watches the processor bus and decides, for each of two DRAM banks, whether the current access belongs to that bank. Each bank is described by a packed 16-bit setting that holds a base address, a compare mask and a valid bit. The bank is placed on a 128 KB boundary, and the topmost address bit is always compared. The bank also carries a write-protect bit and a function-code class bit. For every bank the block reports a hit, a function-code mismatch and a write-protect violation. For the access as a whole it returns either a bus acknowledge after a programmable number of wait states, or a protection error at the same point in time.

A single down-counter, reloaded from a refresh-interval input, paces refresh. When the counter expires, every bank whose refresh enable is set receives a one-cycle request. The interval may be changed while banks are live. The counter picks up the new value at its next reload.

The bank decoding is combinational from the bus pins while the strobe is high. The acknowledge and error timing is registered, and the outcome of an access is fixed at the first clock edge that samples the strobe high.

Top module: `dram_bank_decode`

## Requirements
- R1: Bank setting layout: bits 15:9 hold base A23..A17, bits 6:1 hold compare mask for A22..A17 (1 = compared), bit 0 is valid, bits 8:7 are ignored. A23 is always compared. A bank hits while strobe is high when every compared address bit equals its base bit. 0x0041 covers 0x000000..0x3FFFFF, 0x6071 covers 0x600000..0x6FFFFF and 0x0001 covers 0x000000..0x7FFFFF.
- R2: A bank whose valid bit is 0 gives no hit, no mismatch and no violation, and causes no acknowledge.
- R3: With the class bit at 0 a bank accepts function codes 5 and 6 only. With the class bit at 1 it accepts 1, 2, 5 and 6.
- R4: An address match with a function code the bank does not accept raises that bank's mismatch output, suppresses its hit and its violation, and produces no acknowledge and no protection error.
- R5: A write (write = 1) that hits a write-protected bank raises that bank's violation output. It then yields a protection error instead of an acknowledge, with the same timing. A read of that bank is acknowledged normally.
- R6: For an access that hits, the acknowledge rises W + 1 clock edges after the strobe is first sampled high, where W is the 2-bit wait field. It stays high while strobe stays high and is low after the first edge that samples strobe low.
- R7: An access that hits no bank produces neither acknowledge nor protection error.
- R8: The refresh counter pulses every (interval + 1) clock cycles, and each pulse lasts one cycle.
- R9: A bank's refresh request pulses only when its refresh enable is set. Enabled banks pulse in the same cycle.
- R10: A new refresh interval, written while running, governs every period that starts after the next reload.
- R11: During and right after reset, acknowledge, protection error and refresh requests are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 23 | Bus address A23..A1 |
| fc | input | 3 | Bus function code |
| write | input | 1 | 1 = write, 0 = read |
| strobe | input | 1 | Address strobe, active high |
| bank_cfg | input | 32 | Bank settings, bank b in bits 16b+15..16b |
| wp_en | input | 2 | Per-bank write protect |
| fc_wide | input | 2 | Per-bank function-code class |
| refresh_en | input | 2 | Per-bank refresh enable |
| wait_sel | input | 2 | Shared wait-state count W |
| refresh_rate | input | 12 | Refresh interval reload value |
| bank_hit | output | 2 | Per-bank hit |
| fc_err | output | 2 | Per-bank function-code mismatch |
| wp_err | output | 2 | Per-bank write-protect violation |
| ack | output | 1 | Bus acknowledge |
| prot_err | output | 1 | Protection error in place of acknowledge |
| refresh_req | output | 2 | Per-bank refresh request pulse |

## Verification
The refresh pulse and the delayed acknowledge run on independent timers, so one can land on the same clock edge as the other. The bench provokes this by keeping a short refresh interval while it issues accesses with zero to three wait states, so the two events repeatedly coincide. Each function is judged by its own monitor. One monitor measures every refresh gap against the programmed interval. A scoreboard matches each acknowledge or protection error to the exact cycle predicted when the access was driven. A collision that shifts or drops either event therefore shows up as a wrong cycle or a wrong gap.

// File: rtl/dbd_pkg.sv
// Package for the DRAM bank decoder: bank setting layout and function-code rules.
// Assumes a 16-bit bank setting with a 7-bit base/mask field covering A23..A17.
package dbd_pkg;

    localparam int CFG_W     = 16;
    localparam int FIELD_W   = 7;
    localparam int BASE_LSB  = 9;
    localparam int MASK_LSB  = 1;
    localparam int VALID_BIT = 0;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
        logic               valid;
    } bank_cfg_t;

    // Unpack a raw setting; the top mask bit is forced to compare.
    function automatic bank_cfg_t unpack_cfg(input logic [CFG_W-1:0] raw);
        bank_cfg_t c;
        c.base  = raw[BASE_LSB +: FIELD_W];
        c.mask  = {1'b1, raw[MASK_LSB +: FIELD_W-1]};
        c.valid = raw[VALID_BIT];
        return c;
    endfunction

    // True when a function code belongs to the class selected by 'wide'.
    function automatic logic fc_allowed(input logic [2:0] code, input logic wide);
        logic ok;
        case (code)
            3'd5, 3'd6: ok = 1'b1;
            3'd1, 3'd2: ok = wide;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dbd_bank_match.sv
// Single-bank decoder. Compares the upper address field against the bank's
// base under its mask, qualifies with valid, function-code class and write
// protect. Purely combinational; assumes inputs are stable while strobe is high.
module dbd_bank_match
    import dbd_pkg::*;
(
    input  logic [CFG_W-1:0]   cfg_raw,
    input  logic [FIELD_W-1:0] addr_hi,
    input  logic [2:0]         fc,
    input  logic               write,
    input  logic               strobe,
    input  logic               wp,
    input  logic               wide,
    output logic               hit,
    output logic               fc_err,
    output logic               wp_err
);

    bank_cfg_t cfg;
    logic      region;
    logic      fc_ok;
    logic      cfg_unused;

    assign cfg        = unpack_cfg(cfg_raw);
    assign cfg_unused = ^cfg_raw[BASE_LSB-1:MASK_LSB+FIELD_W-1];

    // Address window compare and function-code qualification.
    always_comb begin
        region = cfg.valid && (((addr_hi ^ cfg.base) & cfg.mask) == '0);
        fc_ok  = fc_allowed(fc, wide);
        hit    = strobe && region && fc_ok;
        fc_err = strobe && region && !fc_ok;
        wp_err = hit && write && wp;
    end

endmodule

// File: rtl/dbd_wait_ack.sv
// Wait-state sequencer. At the first edge that samples strobe high it latches
// whether the access is good, protected or unclaimed, then counts down the
// wait field. Acknowledge or protection error appears W+1 edges after strobe
// and is held until strobe is sampled low.
module dbd_wait_ack #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              any_ok,
    input  logic              any_bad,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic              ack,
    output logic              prot_err
);

    logic              strobe_q;
    logic              busy;
    logic              bad;
    logic [WAIT_W-1:0] cnt;

    // Strobe history for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Access outcome latch and wait countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || !strobe) begin
            busy <= 1'b0;
            bad  <= 1'b0;
            cnt  <= '0;
        end else if (!strobe_q) begin
            busy <= any_ok || any_bad;
            bad  <= any_bad;
            cnt  <= wait_sel;
        end else if (busy && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ack      = busy && !bad && (cnt == '0);
    assign prot_err = busy &&  bad && (cnt == '0);

    assert_ack_prot_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && prot_err));

    assert_resp_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (!ack && !prot_err));

    assert_ack_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(strobe));

endmodule

// File: rtl/dbd_refresh_timer.sv
// Shared refresh pacer. A down-counter reloads from the interval input on
// reaching zero; each enabled bank gets a one-cycle request per expiry.
// The interval is sampled only at reload, so it may change at any time.
module dbd_refresh_timer #(
    parameter int NUM_BANKS = 2,
    parameter int RATE_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RATE_W-1:0]    rate_in,
    input  logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] refresh_req
);

    logic [RATE_W-1:0] cnt;
    logic              tick;

    assign tick = (cnt == '0);

    // Interval countdown with reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= rate_in;
        else                cnt <= cnt - 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_req
        // Per-bank request gated by its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) refresh_req[b] <= 1'b0;
            else        refresh_req[b] <= tick && bank_en[b];
        end

        assert_refresh_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            refresh_req[b] |-> $past(bank_en[b]));

        assert_refresh_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (refresh_req[b] && ($past(rate_in) != '0)) |=> !refresh_req[b]);
    end

endmodule

// File: rtl/dram_bank_decode.sv
// Top of the DRAM bank decoder. Instantiates one matcher per bank, merges
// their results into the wait-state sequencer, and runs the shared refresh
// pacer. Assumes one bus master and a strobe that drops between accesses.
module dram_bank_decode
    import dbd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_MSB  = 23,
    parameter int RATE_W    = 12,
    parameter int WAIT_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_MSB:1]          addr,
    input  logic [2:0]                 fc,
    input  logic                       write,
    input  logic                       strobe,
    input  logic [NUM_BANKS*CFG_W-1:0] bank_cfg,
    input  logic [NUM_BANKS-1:0]       wp_en,
    input  logic [NUM_BANKS-1:0]       fc_wide,
    input  logic [NUM_BANKS-1:0]       refresh_en,
    input  logic [WAIT_W-1:0]          wait_sel,
    input  logic [RATE_W-1:0]          refresh_rate,
    output logic [NUM_BANKS-1:0]       bank_hit,
    output logic [NUM_BANKS-1:0]       fc_err,
    output logic [NUM_BANKS-1:0]       wp_err,
    output logic                       ack,
    output logic                       prot_err,
    output logic [NUM_BANKS-1:0]       refresh_req
);

    localparam int BLK_LSB = ADDR_MSB - FIELD_W + 1;

    logic [FIELD_W-1:0] addr_hi;
    logic               addr_unused;
    logic               any_bad;
    logic               any_ok;

    assign addr_hi     = addr[ADDR_MSB:BLK_LSB];
    assign addr_unused = ^addr[BLK_LSB-1:1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dbd_bank_match u_match (
            .cfg_raw (bank_cfg[b*CFG_W +: CFG_W]),
            .addr_hi (addr_hi),
            .fc      (fc),
            .write   (write),
            .strobe  (strobe),
            .wp      (wp_en[b]),
            .wide    (fc_wide[b]),
            .hit     (bank_hit[b]),
            .fc_err  (fc_err[b]),
            .wp_err  (wp_err[b])
        );
    end

    // Merge bank results: any violation overrides a clean hit.
    always_comb begin
        any_bad = |wp_err;
        any_ok  = (|bank_hit) && !any_bad;
    end

    dbd_wait_ack #(.WAIT_W(WAIT_W)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .any_ok   (any_ok),
        .any_bad  (any_bad),
        .wait_sel (wait_sel),
        .ack      (ack),
        .prot_err (prot_err)
    );

    dbd_refresh_timer #(.NUM_BANKS(NUM_BANKS), .RATE_W(RATE_W)) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_in     (refresh_rate),
        .bank_en     (refresh_en),
        .refresh_req (refresh_req)
    );

endmodule

// File: tb/tb_dram_bank_decode.sv
module tb_dram_bank_decode;

    localparam int NB = 2;
    localparam int AMSB = 23;
    localparam int RW = 12;
    localparam int WW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AMSB:1]    addr = '0;
    logic [2:0]       fc = 3'd0;
    logic             write = 1'b0;
    logic             strobe = 1'b0;
    logic [NB*16-1:0] bank_cfg = '0;
    logic [NB-1:0]    wp_en = '0;
    logic [NB-1:0]    fc_wide = '0;
    logic [NB-1:0]    refresh_en = 2'b01;
    logic [WW-1:0]    wait_sel = '0;
    logic [RW-1:0]    refresh_rate = 12'd7;
    logic [NB-1:0]    bank_hit, fc_err, wp_err, refresh_req;
    logic             ack, prot_err;

    dram_bank_decode dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .fc(fc), .write(write),
        .strobe(strobe), .bank_cfg(bank_cfg), .wp_en(wp_en), .fc_wide(fc_wide),
        .refresh_en(refresh_en), .wait_sel(wait_sel), .refresh_rate(refresh_rate),
        .bank_hit(bank_hit), .fc_err(fc_err), .wp_err(wp_err), .ack(ack),
        .prot_err(prot_err), .refresh_req(refresh_req)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Scoreboard: kind 1 = acknowledge, 2 = protection error.
    typedef struct { int kind; int cyc; string tag; } exp_t;
    exp_t sb_q[$];
    int   events = 0;
    logic ack_q = 1'b0;
    logic perr_q = 1'b0;

    always @(negedge clk) begin
        exp_t it;
        int   kind;
        if ((ack && !ack_q) || (prot_err && !perr_q)) begin
            kind = ack ? 1 : 2;
            events++;
            if (sb_q.size() == 0) begin
                chk("R7 unexpected response", kind, 0);
            end else begin
                it = sb_q.pop_front();
                chk({it.tag, " response kind"}, kind, it.kind);
                chk({it.tag, " response cycle"}, cyc, it.cyc);
            end
        end
        ack_q  = ack;
        perr_q = prot_err;
    end

    // Refresh monitor.
    int last0 = -1;
    int skip0 = 0;
    int cur_rate = 7;
    int n_gap = 0;
    int cnt1 = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            last0 = -1;
        end else begin
            if (refresh_req[0]) begin
                if (last0 >= 0) begin
                    if (skip0 > 0) skip0--;
                    else begin
                        chk("R8 refresh interval", cyc - last0, cur_rate + 1);
                        n_gap++;
                    end
                end
                last0 = cyc;
            end
            if (refresh_req[1]) begin
                cnt1++;
                chk("R9 enabled banks pulse together", int'(refresh_req[0]), 1);
            end
        end
    end

    // Driver: one access, expectations pushed before the response can appear.
    task automatic do_access(input logic [23:0] a, input logic [2:0] f, input logic wr,
                             input logic [1:0] e_hit, input logic [1:0] e_fce,
                             input logic [1:0] e_wpe, input string tag);
        int kind;
        int ev0;
        int w;
        kind = (e_wpe != 0) ? 2 : ((e_hit != 0) ? 1 : 0);
        w = int'(wait_sel);
        @(negedge clk);
        addr = a[23:1];
        fc = f;
        write = wr;
        strobe = 1'b1;
        ev0 = events;
        if (kind != 0) sb_q.push_back('{kind, cyc + 1 + w, tag});
        #2;
        chk({tag, " bank_hit"}, int'(bank_hit), int'(e_hit));
        chk({tag, " fc_err"}, int'(fc_err), int'(e_fce));
        chk({tag, " wp_err"}, int'(wp_err), int'(e_wpe));
        repeat (w + 3) @(negedge clk);
        #2;
        chk({tag, " R6 ack held"}, int'(ack), (kind == 1) ? 1 : 0);
        chk({tag, " R6 prot_err held"}, int'(prot_err), (kind == 2) ? 1 : 0);
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        #2;
        chk({tag, " R6 response cleared"}, int'(ack | prot_err), 0);
        @(negedge clk);
        chk({tag, " response count"}, events - ev0, (kind != 0) ? 1 : 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bank_cfg = {16'h6070, 16'h0041};
        repeat (3) @(negedge clk);
        chk("R11 ack in reset", int'(ack), 0);
        chk("R11 prot_err in reset", int'(prot_err), 0);
        chk("R11 refresh in reset", int'(refresh_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 outputs after reset", int'({ack, prot_err, refresh_req}), 0);

        do_access(24'h123456, 3'd5, 1'b0, 2'b01, 2'b00, 2'b00, "R1 4MB bank interior");
        do_access(24'h3FFFFE, 3'd6, 1'b1, 2'b01, 2'b00, 2'b00, "R1 4MB bank top write");
        do_access(24'h400000, 3'd5, 1'b0, 2'b00, 2'b00, 2'b00, "R7 just above bank0");
        do_access(24'h612340, 3'd5, 1'b0, 2'b00, 2'b00, 2'b00, "R2 invalid bank1");
        bank_cfg[31:16] = 16'h6071;
        do_access(24'h612340, 3'd5, 1'b0, 2'b10, 2'b00, 2'b00, "R1 1MB bank1");
        do_access(24'h700000, 3'd5, 1'b0, 2'b00, 2'b00, 2'b00, "R7 above bank1");
        do_access(24'h5FFFFE, 3'd6, 1'b0, 2'b00, 2'b00, 2'b00, "R1 below bank1");
        bank_cfg[15:0] = 16'h0001;
        do_access(24'h7FFFFE, 3'd5, 1'b0, 2'b01, 2'b00, 2'b00, "R1 unmasked bank top");
        do_access(24'h800000, 3'd5, 1'b0, 2'b00, 2'b00, 2'b00, "R1 A23 always compared");
        bank_cfg[15:0] = 16'h0041;
        do_access(24'h001000, 3'd1, 1'b0, 2'b00, 2'b01, 2'b00, "R3 R4 narrow rejects fc1");
        do_access(24'h001000, 3'd2, 1'b0, 2'b00, 2'b01, 2'b00, "R3 narrow rejects fc2");
        fc_wide[0] = 1'b1;
        do_access(24'h001000, 3'd1, 1'b0, 2'b01, 2'b00, 2'b00, "R3 wide accepts fc1");
        do_access(24'h001000, 3'd2, 1'b0, 2'b01, 2'b00, 2'b00, "R3 wide accepts fc2");
        do_access(24'h001000, 3'd3, 1'b0, 2'b00, 2'b01, 2'b00, "R3 wide rejects fc3");
        do_access(24'h001000, 3'd7, 1'b0, 2'b00, 2'b01, 2'b00, "R4 fc7 mismatch");
        wait_sel = 2'd3;
        do_access(24'h123456, 3'd6, 1'b0, 2'b01, 2'b00, 2'b00, "R6 three wait states");
        wait_sel = 2'd2;
        do_access(24'h654320, 3'd5, 1'b0, 2'b10, 2'b00, 2'b00, "R6 two wait states bank1");
        wp_en[1] = 1'b1;
        do_access(24'h654320, 3'd5, 1'b1, 2'b10, 2'b00, 2'b10, "R5 write to protected bank");
        do_access(24'h654320, 3'd5, 1'b0, 2'b10, 2'b00, 2'b00, "R5 read of protected bank");
        do_access(24'h654320, 3'd1, 1'b1, 2'b00, 2'b10, 2'b00, "R4 mismatch hides protection");
        wait_sel = 2'd1;
        do_access(24'h200000, 3'd6, 1'b1, 2'b01, 2'b00, 2'b00, "R6 one wait state");

        chk("R9 disabled bank1 silent", cnt1, 0);

        @(posedge clk);
        #5;
        refresh_rate = 12'd12;
        cur_rate = 12;
        skip0 = 1;
        n_gap = 0;
        repeat (60) @(negedge clk);
        chk("R10 new interval observed", int'(n_gap >= 2), 1);

        refresh_en = 2'b11;
        repeat (45) @(negedge clk);
        chk("R9 enabled bank1 pulses", int'(cnt1 >= 2), 1);
        chk("R7 scoreboard drained", sb_q.size(), 0);

        finish_run();
    end

endmodule